// File: doc/BRIEF.md
# Windowed Independent Watchdog

The block is a watchdog timer that runs from its own slow clock, independent of the bus clock that programs it. A prescaler divides the slow clock by a power of two, and each prescaled tick decrements a 12-bit counter. Software arms the watchdog with a start key. It then has to keep it alive with a refresh key, which reloads the counter with the programmed reload value.

A programmable window limits when a refresh is allowed. A refresh that arrives while the counter is still above the window value is treated as a fault. So is a counter that runs out. In both cases the block drives a fixed-length reset request and sets a sticky cause flag. The block itself is not reset by that request, so software can read the flag when it comes back up.

Configuration writes cross into the slow domain through a toggle handshake. A busy bit is set while the handshake is in flight, and further writes to the three configuration fields are dropped until it clears. Once armed, the watchdog cannot be stopped.

Top module: `winwdg_top`

## Requirements
- R1: After reset the request output is low and the status word (offset 4) reads 0. Offset 1 reads 6, giving a prescaler of 256. Offsets 2 and 3 read 0xFFF.
- R2: Writing 0xCCCC to offset 0 arms the watchdog, and status bit 2 reads 1 while it counts. While idle, a refresh key or any other value written there leaves it idle, with no request.
- R3: Prescaler field p (offset 1, bits 2:0) divides the slow clock by 2^(p+2). The counter starts at the reload value (offset 2) and falls by one per tick. The tick that finds it at zero raises the request, between (reload+1)*2^(p+2) and that figure plus 8 slow cycles after the start write.
- R4: The request stays high for exactly RST_LEN slow cycles (default 4). The watchdog then stays idle with no further request until it is armed again.
- R5: Writing 0xAAAA to offset 0 while the counter is at or below the window reloads the counter and restarts the prescaler. The next expiry then falls (reload+1)*2^(p+2) to that figure plus 8 slow cycles after that write.
- R6: A refresh while the counter is above the window (offset 3) raises the request within 8 slow cycles. A window of 0 makes any refresh with a non-zero count fatal. A window of 0xFFF never faults.
- R7: Once armed, the watchdog keeps counting whatever is written, including a repeated start key.
- R8: Status bit 1 is set by every watchdog request. It stays set through later starts and refreshes. Only writing 1 to bit 1 of offset 4 clears it, and writing 0 there leaves it.
- R9: A write to offsets 1 to 3 sets status bit 0 (busy) from the next bus cycle until the value is in use in the slow domain. Configuration writes made while busy is set are ignored.
- R10: Any value other than the two keys written to offset 0 while counting has no effect on the expiry time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset, bus domain |
| lclk | input | 1 | Slow independent watchdog clock |
| lrst_n | input | 1 | Synchronous active-low reset, slow domain |
| bus_wr | input | 1 | Write strobe, one bus cycle per write |
| bus_addr | input | 3 | Word offset: 0 key, 1 prescaler, 2 reload, 3 window, 4 status |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr, combinational |
| wdg_rst_req | output | 1 | Reset request pulse, slow domain |

## Verification
The busy bit is due at the bus edge that ends a configuration write. The bench reads it immediately and otherwise polls it until it clears before it arms the watchdog. Start and refresh commands take effect about three slow edges after the write. Expiry follows after (reload+1) prescaled periods, so every timed check counts slow clock cycles from the write and accepts an 8-cycle band above the computed figure. The pulse width is counted exactly. Window faults must appear within 8 slow cycles, while "nothing happens" checks wait well beyond that band and compare a count of request rises taken before and after.

// File: rtl/winwdg_pkg.sv
// Shared constants and types for the windowed watchdog.
// Assumes a 12-bit counter and a 3-bit prescaler field.
package winwdg_pkg;
    localparam int CNT_W  = 12;
    localparam int PRE_W  = 3;
    localparam int DATA_W = 16;
    localparam int ADDR_W = 3;

    localparam logic [ADDR_W-1:0] OFS_KEY    = 3'd0;
    localparam logic [ADDR_W-1:0] OFS_PRESC  = 3'd1;
    localparam logic [ADDR_W-1:0] OFS_RELOAD = 3'd2;
    localparam logic [ADDR_W-1:0] OFS_WINDOW = 3'd3;
    localparam logic [ADDR_W-1:0] OFS_STATUS = 3'd4;

    localparam logic [DATA_W-1:0] KEY_ARM  = 16'hCCCC;
    localparam logic [DATA_W-1:0] KEY_FEED = 16'hAAAA;

    typedef struct packed {
        logic [PRE_W-1:0] presc;
        logic [CNT_W-1:0] reload;
        logic [CNT_W-1:0] window;
    } wdg_cfg_t;

    typedef enum logic [1:0] {
        WS_IDLE = 2'd0,
        WS_RUN  = 2'd1,
        WS_FIRE = 2'd2
    } wdg_state_e;
endpackage

// File: rtl/winwdg_sync.sv
// Multi-stage flip-flop synchroniser for a bundle of independent bits.
// Assumes each bit is a level or a toggle; no multi-bit coherence is given.
module winwdg_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    // First stage samples the foreign-domain input.
    always_ff @(posedge clk) begin
        if (!rst_n) stg[0] <= '0;
        else        stg[0] <= d;
    end

    genvar gi;
    generate
        for (gi = 1; gi < STAGES; gi++) begin : g_stage
            // Each further stage gives metastability time to settle.
            always_ff @(posedge clk) begin
                if (!rst_n) stg[gi] <= '0;
                else        stg[gi] <= stg[gi-1];
            end
        end
    endgenerate

    assign q = stg[STAGES-1];
endmodule

// File: rtl/winwdg_regs.sv
// Bus-domain register file: shadow configuration, key decode into toggles,
// busy tracking for the configuration handshake and the read mux.
// Assumes cfg_ack_s, flag_s and run_s are already synchronised into clk.
module winwdg_regs
    import winwdg_pkg::*;
#(
    parameter int PRESC_INIT = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              cfg_ack_s,
    input  logic              flag_s,
    input  logic              run_s,
    output wdg_cfg_t          cfg,
    output logic              cfg_req,
    output logic              arm_tgl,
    output logic              feed_tgl,
    output logic              clr_tgl
);
    logic busy;
    logic cfg_hit;

    assign busy    = cfg_req != cfg_ack_s;
    assign cfg_hit = bus_wr && (bus_addr == OFS_PRESC || bus_addr == OFS_RELOAD ||
                                bus_addr == OFS_WINDOW);

    // Decode writes: keys flip command toggles, config writes need an idle handshake.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg.presc  <= PRE_W'(PRESC_INIT);
            cfg.reload <= '1;
            cfg.window <= '1;
            cfg_req    <= 1'b0;
            arm_tgl    <= 1'b0;
            feed_tgl   <= 1'b0;
            clr_tgl    <= 1'b0;
        end else if (bus_wr) begin
            case (bus_addr)
                OFS_KEY: begin
                    if (bus_wdata == KEY_ARM)       arm_tgl  <= ~arm_tgl;
                    else if (bus_wdata == KEY_FEED) feed_tgl <= ~feed_tgl;
                end
                OFS_PRESC: if (!busy) begin
                    cfg.presc <= bus_wdata[PRE_W-1:0];
                    cfg_req   <= ~cfg_req;
                end
                OFS_RELOAD: if (!busy) begin
                    cfg.reload <= bus_wdata[CNT_W-1:0];
                    cfg_req    <= ~cfg_req;
                end
                OFS_WINDOW: if (!busy) begin
                    cfg.window <= bus_wdata[CNT_W-1:0];
                    cfg_req    <= ~cfg_req;
                end
                OFS_STATUS: if (bus_wdata[1]) clr_tgl <= ~clr_tgl;
                default: ;
            endcase
        end
    end

    // Read mux over the shadow values and synchronised status.
    always_comb begin
        case (bus_addr)
            OFS_PRESC:  bus_rdata = DATA_W'(cfg.presc);
            OFS_RELOAD: bus_rdata = DATA_W'(cfg.reload);
            OFS_WINDOW: bus_rdata = DATA_W'(cfg.window);
            OFS_STATUS: bus_rdata = DATA_W'({run_s, flag_s, busy});
            default:    bus_rdata = '0;
        endcase
    end

    // R9: shadow configuration must not move while a transfer is pending.
    a_r9_hold_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_hit && busy) |=> $stable(cfg));

    // R9: an accepted configuration write raises busy on the next edge.
    a_r9_busy_after_write: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_hit && !busy) |=> busy);
endmodule

// File: rtl/winwdg_core.sv
// Slow-domain watchdog engine: captures configuration, runs the prescaler
// and down-counter, judges refresh timing against the window, drives the
// reset pulse and holds the sticky cause flag.
// Assumes all *_s inputs are synchronised into lclk and cfg_in is held
// stable by the bus side while cfg_req_s differs from cfg_ack.
module winwdg_core
    import winwdg_pkg::*;
#(
    parameter int RST_LEN    = 4,
    parameter int PRESC_INIT = 6
) (
    input  logic     lclk,
    input  logic     lrst_n,
    input  wdg_cfg_t cfg_in,
    input  logic     cfg_req_s,
    input  logic     arm_s,
    input  logic     feed_s,
    input  logic     clr_s,
    output logic     cfg_ack,
    output logic     rst_req,
    output logic     running,
    output logic     flag
);
    localparam int PC_W = (1 << PRE_W) + 1;
    localparam int RL_W = $clog2(RST_LEN + 1);

    wdg_cfg_t          cfg_live;
    wdg_state_e        st;
    logic [CNT_W-1:0]  cnt;
    logic [PC_W-1:0]   pc;
    logic [PC_W-1:0]   div_m1;
    logic [RL_W-1:0]   rlen;
    logic              arm_q, feed_q, clr_q;
    logic              arm_p, feed_p, clr_p;
    logic              tick, fault;

    assign arm_p  = arm_s  ^ arm_q;
    assign feed_p = feed_s ^ feed_q;
    assign clr_p  = clr_s  ^ clr_q;
    assign div_m1 = (PC_W'(1) << ({1'b0, cfg_live.presc} + 4'd2)) - PC_W'(1);
    assign tick   = pc >= div_m1;
    assign running = st == WS_RUN;

    // Fault when a refresh comes above the window or a tick finds zero.
    always_comb begin
        fault = 1'b0;
        if (st == WS_RUN) begin
            if (feed_p)                    fault = cnt > cfg_live.window;
            else if (tick && cnt == '0)    fault = 1'b1;
        end
    end

    // Edge detection of command toggles and configuration capture.
    always_ff @(posedge lclk) begin
        if (!lrst_n) begin
            arm_q           <= 1'b0;
            feed_q          <= 1'b0;
            clr_q           <= 1'b0;
            cfg_ack         <= 1'b0;
            cfg_live.presc  <= PRE_W'(PRESC_INIT);
            cfg_live.reload <= '1;
            cfg_live.window <= '1;
        end else begin
            arm_q  <= arm_s;
            feed_q <= feed_s;
            clr_q  <= clr_s;
            if (cfg_req_s != cfg_ack) begin
                cfg_live <= cfg_in;
                cfg_ack  <= cfg_req_s;
            end
        end
    end

    // Main state machine: idle, counting, and firing the reset pulse.
    always_ff @(posedge lclk) begin
        if (!lrst_n) begin
            st      <= WS_IDLE;
            cnt     <= '1;
            pc      <= '0;
            rlen    <= '0;
            rst_req <= 1'b0;
        end else begin
            case (st)
                WS_IDLE: begin
                    if (arm_p) begin
                        st  <= WS_RUN;
                        cnt <= cfg_live.reload;
                        pc  <= '0;
                    end
                end
                WS_RUN: begin
                    if (fault) begin
                        st      <= WS_FIRE;
                        rst_req <= 1'b1;
                        rlen    <= '0;
                    end else if (feed_p) begin
                        cnt <= cfg_live.reload;
                        pc  <= '0;
                    end else if (tick) begin
                        cnt <= cnt - CNT_W'(1);
                        pc  <= '0;
                    end else begin
                        pc <= pc + PC_W'(1);
                    end
                end
                WS_FIRE: begin
                    if (rlen == RL_W'(RST_LEN - 1)) begin
                        st      <= WS_IDLE;
                        rst_req <= 1'b0;
                        cnt     <= cfg_live.reload;
                    end else begin
                        rlen <= rlen + RL_W'(1);
                    end
                end
                default: st <= WS_IDLE;
            endcase
        end
    end

    // Sticky cause flag: set by a fault, cleared only by an explicit clear.
    always_ff @(posedge lclk) begin
        if (!lrst_n)    flag <= 1'b0;
        else if (fault) flag <= 1'b1;
        else if (clr_p) flag <= 1'b0;
    end

    // R3: while counting, the counter only steps down by one or reloads.
    a_r3_step: assert property (@(posedge lclk) disable iff (!lrst_n)
        (st == WS_RUN && $past(st) == WS_RUN && cnt != $past(cnt)) |->
        (cnt == $past(cnt) - CNT_W'(1) || cnt == $past(cfg_live.reload)));

    // R4: after the pulse ends the engine is idle.
    a_r4_idle_after: assert property (@(posedge lclk) disable iff (!lrst_n)
        $fell(rst_req) |-> (st == WS_IDLE));

    generate
        if (RST_LEN > 1) begin : g_pulse_chk
            // R4: a pulse lasts beyond its first cycle.
            a_r4_pulse_hold: assert property (@(posedge lclk) disable iff (!lrst_n)
                $rose(rst_req) |=> rst_req);
        end
    endgenerate

    // R6: a refresh above the window fires the request on the next edge.
    a_r6_early_feed: assert property (@(posedge lclk) disable iff (!lrst_n)
        (st == WS_RUN && feed_p && cnt > cfg_live.window) |=> rst_req);

    // R7: counting never returns straight to idle.
    a_r7_no_stop: assert property (@(posedge lclk) disable iff (!lrst_n)
        (st == WS_RUN) |=> (st != WS_IDLE));

    // R8: every request comes with the cause flag set.
    a_r8_flag_set: assert property (@(posedge lclk) disable iff (!lrst_n)
        $rose(rst_req) |-> flag);
endmodule

// File: rtl/winwdg_top.sv
// Windowed watchdog top: bus-domain registers, synchronisers in both
// directions and the slow-domain engine.
// Assumes lclk and clk are unrelated; the request output is in lclk.
module winwdg_top
    import winwdg_pkg::*;
#(
    parameter int RST_LEN     = 4,
    parameter int SYNC_STAGES = 2,
    parameter int PRESC_INIT  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lclk,
    input  logic              lrst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              wdg_rst_req
);
    wdg_cfg_t cfg;
    logic cfg_req, arm_tgl, feed_tgl, clr_tgl;
    logic cfg_req_s, arm_s, feed_s, clr_s;
    logic cfg_ack, flag, running;
    logic cfg_ack_s, flag_s, run_s;

    winwdg_regs #(.PRESC_INIT(PRESC_INIT)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata),
        .cfg_ack_s(cfg_ack_s), .flag_s(flag_s), .run_s(run_s),
        .cfg(cfg), .cfg_req(cfg_req),
        .arm_tgl(arm_tgl), .feed_tgl(feed_tgl), .clr_tgl(clr_tgl)
    );

    winwdg_sync #(.W(4), .STAGES(SYNC_STAGES)) u_to_slow (
        .clk(lclk), .rst_n(lrst_n),
        .d({cfg_req, arm_tgl, feed_tgl, clr_tgl}),
        .q({cfg_req_s, arm_s, feed_s, clr_s})
    );

    winwdg_sync #(.W(3), .STAGES(SYNC_STAGES)) u_to_bus (
        .clk(clk), .rst_n(rst_n),
        .d({cfg_ack, flag, running}),
        .q({cfg_ack_s, flag_s, run_s})
    );

    winwdg_core #(.RST_LEN(RST_LEN), .PRESC_INIT(PRESC_INIT)) u_core (
        .lclk(lclk), .lrst_n(lrst_n),
        .cfg_in(cfg), .cfg_req_s(cfg_req_s),
        .arm_s(arm_s), .feed_s(feed_s), .clr_s(clr_s),
        .cfg_ack(cfg_ack), .rst_req(wdg_rst_req),
        .running(running), .flag(flag)
    );
endmodule

// File: tb/sim_winwdg_top.sv
module sim_winwdg_top;
    logic clk = 1'b0, lclk = 1'b0;
    logic rst_n, lrst_n, bus_wr;
    logic [2:0]  bus_addr;
    logic [15:0] bus_wdata, bus_rdata;
    logic wdg_rst_req;
    int checks = 0, fails = 0, rises = 0;
    logic prev_req = 1'b0;

    localparam int RLEN = 4;

    always #2  clk  = ~clk;
    always #10 lclk = ~lclk;

    winwdg_top #(.RST_LEN(RLEN)) u0 (
        .clk(clk), .rst_n(rst_n), .lclk(lclk), .lrst_n(lrst_n),
        .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .wdg_rst_req(wdg_rst_req)
    );

    // Count request rises, sampled away from the slow edge.
    always @(negedge lclk) begin
        if (wdg_rst_req === 1'b1 && prev_req == 1'b0) rises++;
        prev_req = (wdg_rst_req === 1'b1);
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [15:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic lwait(input int n);
        repeat (n) @(negedge lclk);
    endtask

    task automatic wait_idle();
        logic [15:0] v;
        int k = 0;
        rd(3'd4, v);
        while (v[0] && k < 500) begin rd(3'd4, v); k++; end
    endtask

    task automatic set_cfg(input int p, input int r, input int w);
        wait_idle(); wr(3'd1, 16'(p));
        wait_idle(); wr(3'd2, 16'(r));
        wait_idle(); wr(3'd3, 16'(w));
        wait_idle();
    endtask

    task automatic wait_rst(input int limit, inout int n);
        while (wdg_rst_req !== 1'b1 && n < limit) begin @(negedge lclk); n++; end
    endtask

    task automatic wait_pulse_end(output int n);
        n = 0;
        while (wdg_rst_req === 1'b1 && n < 100) begin @(negedge lclk); n++; end
        lwait(4);
    endtask

    function automatic int period(input int p, input int r);
        return (r + 1) * (1 << (p + 2));
    endfunction

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    initial begin
        #600000;
        fails++;
        $display("FAIL watchdog expired: actual=timeout expected=finish");
        summary();
        $finish;
    end

    initial begin
        logic [15:0] v;
        int n, base, p, r, exp;
        void'($urandom(32'd2024));
        rst_n = 1'b0; lrst_n = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
        lwait(10);
        rst_n = 1'b1; lrst_n = 1'b1;
        lwait(3);

        // R1: reset state
        rd(3'd4, v); chk(v == 0, "R1 status", v, 0);
        rd(3'd1, v); chk(v == 6, "R1 prescaler", v, 6);
        rd(3'd2, v); chk(v == 16'hFFF, "R1 reload", v, 4095);
        rd(3'd3, v); chk(v == 16'hFFF, "R1 window", v, 4095);
        chk(wdg_rst_req == 1'b0, "R1 request", wdg_rst_req, 0);

        // R9: busy after write, writes while busy dropped
        wr(3'd2, 16'd20);
        rd(3'd4, v); chk(v[0] == 1'b1, "R9 busy", v[0], 1);
        wr(3'd2, 16'd99);
        wait_idle();
        rd(3'd2, v); chk(v == 20, "R9 write while busy ignored", v, 20);

        // R2: refresh or junk while idle does nothing
        base = rises;
        wr(3'd0, 16'hAAAA); lwait(20);
        rd(3'd4, v); chk(v[2] == 1'b0, "R2 refresh in idle", v[2], 0);
        wr(3'd0, 16'h1234); lwait(20);
        rd(3'd4, v); chk(v[2] == 1'b0, "R2 junk key in idle", v[2], 0);
        chk(rises == base, "R2 no request in idle", rises - base, 0);

        // R3 and R4: directed expiry, pulse width, then idle
        set_cfg(0, 20, 4095);
        wr(3'd0, 16'hCCCC);
        lwait(6);
        rd(3'd4, v); chk(v[2] == 1'b1, "R2 start key arms", v[2], 1);
        n = 6; wait_rst(2000, n);
        exp = period(0, 20);
        chk(n >= exp && n <= exp + 8, "R3 expiry time", n, exp);
        wait_pulse_end(n);
        chk(n == RLEN, "R4 pulse length", n, RLEN);
        base = rises;
        lwait(200);
        rd(3'd4, v);
        chk(v[2] == 1'b0, "R4 idle after pulse", v[2], 0);
        chk(rises == base, "R4 no further request", rises - base, 0);
        chk(v[1] == 1'b1, "R8 flag set", v[1], 1);

        // R3 / R10: random prescaler and reload, junk key on odd rounds
        for (int i = 0; i < 4; i++) begin
            p = int'($urandom % 2);
            r = 5 + int'($urandom % 36);
            set_cfg(p, r, 4095);
            wr(3'd0, 16'hCCCC);
            n = 0;
            if (i % 2 == 1) begin
                lwait(10); n = 10;
                wr(3'd0, 16'h5A5A);
            end
            wait_rst(5000, n);
            exp = period(p, r);
            chk(n >= exp && n <= exp + 8, (i % 2 == 1) ? "R10 junk key no effect" : "R3 random expiry", n, exp);
            wait_pulse_end(n);
        end

        // R8: flag sticky, write of 0 keeps it, write of 1 clears
        rd(3'd4, v); chk(v[1] == 1'b1, "R8 flag sticky", v[1], 1);
        wr(3'd4, 16'h0000); lwait(20);
        rd(3'd4, v); chk(v[1] == 1'b1, "R8 zero write keeps flag", v[1], 1);
        wr(3'd4, 16'h0002); lwait(20);
        rd(3'd4, v); chk(v[1] == 1'b0, "R8 clear", v[1], 0);

        // R5 and R7: periodic refreshes keep it alive, cannot be stopped
        set_cfg(0, 30, 4095);
        wr(3'd0, 16'hCCCC); lwait(20);
        wr(3'd0, 16'hCCCC); wr(3'd0, 16'h0000); lwait(5);
        rd(3'd4, v); chk(v[2] == 1'b1, "R7 still running", v[2], 1);
        base = rises;
        for (int k = 0; k < 5; k++) begin
            lwait(60);
            wr(3'd0, 16'hAAAA);
        end
        chk(rises == base, "R5 refreshes prevent expiry", rises - base, 0);
        rd(3'd4, v); chk(v[1] == 1'b0 && v[2] == 1'b1, "R7 running after refreshes", v[2:1], 2);
        n = 0; wait_rst(1000, n);
        exp = period(0, 30);
        chk(n >= exp && n <= exp + 8, "R5 expiry after last refresh", n, exp);
        wait_pulse_end(n);

        // R6: early refresh faults
        set_cfg(0, 40, 20);
        wr(3'd0, 16'hCCCC); lwait(10);
        wr(3'd0, 16'hAAAA);
        n = 0; wait_rst(50, n);
        chk(wdg_rst_req === 1'b1 && n <= 8, "R6 early refresh", n, 8);
        wait_pulse_end(n);

        // R6: refresh inside the window accepted
        wr(3'd0, 16'hCCCC); lwait(92);
        base = rises;
        wr(3'd0, 16'hAAAA); lwait(40);
        chk(rises == base, "R6 refresh in window accepted", rises - base, 0);
        n = 0; wait_rst(400, n);
        chk(wdg_rst_req === 1'b1, "R6 expiry after accepted refresh", wdg_rst_req, 1);
        wait_pulse_end(n);

        // R6: window zero makes refresh fatal
        set_cfg(0, 40, 0);
        wr(3'd0, 16'hCCCC); lwait(10);
        wr(3'd0, 16'hAAAA);
        n = 0; wait_rst(50, n);
        chk(wdg_rst_req === 1'b1 && n <= 8, "R6 window zero", n, 8);
        wait_pulse_end(n);

        // R6: window all ones never faults
        set_cfg(0, 40, 4095);
        wr(3'd0, 16'hCCCC); lwait(10);
        base = rises;
        wr(3'd0, 16'hAAAA); lwait(40);
        chk(rises == base, "R6 window max disables check", rises - base, 0);
        n = 0; wait_rst(400, n);
        wait_pulse_end(n);

        summary();
        $finish;
    end
endmodule